// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

This block holds a small set of lock tokens that two independent agents, called the left and the right port, use to agree on who may touch a shared resource. Each port has its own synchronous bus on a common clock. The bus has a select, a write strobe, a token index, write data and read data. A port asks for a token by writing 0 to its own request latch for that token. It gives the token up by writing 1 to the same latch.

A port learns whether it won by reading the token back after the write. The read returns 0 on the side that owns the token and 1 everywhere else. A request that loses is not dropped. It stays latched and takes the token on the same clock edge at which the owner releases it. The losing side must therefore either keep polling or withdraw its request by writing 1. When both sides ask for a free token on the same edge, the left side gets it.

Each token is a three-state machine. The states are FREE, HELD_L and HELD_R. The transitions are:
- FREE to HELD_L: grant on a left request.
- FREE to HELD_R: grant on a right request when there is no left request.
- HELD_L to HELD_R, or HELD_R to HELD_L: handover when the owner releases while the other side is pending.
- HELD_L to FREE, or HELD_R to FREE: release when the other side is not pending.
- Any held state to itself: hold, while the owner's latch stays at 0.

Top module: `dual_sem_bank`

## Requirements
- R1: A synchronous active-high reset sets every request latch to 1 and every token to FREE. After reset, both read-data outputs are 1.
- R2: A port that writes 0 to a FREE token that the other side is not requesting owns it from the next edge. A read by the owner then returns 0 and a read by the other side returns 1.
- R3: While a token is owned, a 0 written by the other side leaves the ownership unchanged. Reads keep returning 0 to the owner and 1 to the requester.
- R4: When the owner writes 1 while the other side's latch holds 0, ownership passes to the other side on that same edge.
- R5: If both ports write 0 to the same FREE token on the same edge, the left port is granted and the right request stays pending.
- R6: A side that writes 1 to withdraw a pending request never gains the token from that request. A token whose owner releases with no pending request becomes FREE, and both sides then read 1.
- R7: The bank has eight tokens, selected by a 3-bit index. A request or release on one token does not change any other token.
- R8: An owner that writes 0 again to its own token keeps ownership and causes no change of state.
- R9: A read is a cycle with select high and write strobe low. Read data appears one cycle after the read. Ownership is reported in bit 0 (0 = this side owns) and the upper bits are 0. A read in the same cycle as a write by the other side to that token returns the state from before the write.
- R10: Only bit 0 of the write data is used as the latch value; the upper bits have no effect. Read data holds its value in cycles without a read.
- R11: The two ports never both read 0 for the same token in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous reset, active high |
| l_cs | input | 1 | Left port select |
| l_we | input | 1 | Left write strobe (1 = write, 0 = read) |
| l_addr | input | 3 | Left token index |
| l_wdata | input | 8 | Left write data, bit 0 is the latch value |
| l_rdata | output | 8 | Left read data, bit 0 is 0 when left owns |
| r_cs | input | 1 | Right port select |
| r_we | input | 1 | Right write strobe (1 = write, 0 = read) |
| r_addr | input | 3 | Right token index |
| r_wdata | input | 8 | Right write data, bit 0 is the latch value |
| r_rdata | output | 8 | Right read data, bit 0 is 0 when right owns |

## Verification
The assertions take for granted that every input is a known value at each rising edge and changes only away from that edge. They also take for granted that the token index is always within the bank, which holds for any 3-bit value. The stimulus is driven on falling edges from bench tasks, so it stays inside these assumptions. The directed part covers pending requests, handover, ties, withdrawal and same-cycle read and write. A random part then biases the index toward a few tokens so that the two ports collide often.

// File: rtl/sem_pkg.sv
package sem_pkg;
    typedef enum logic [1:0] {
        TOK_FREE   = 2'd0,
        TOK_HELD_L = 2'd1,
        TOK_HELD_R = 2'd2
    } tok_state_t;
endpackage

// File: rtl/sem_token_cell.sv
module sem_token_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic l_wr,
    input  logic l_val,
    input  logic r_wr,
    input  logic r_val,
    output logic own_l,
    output logic own_r
);
    logic       lat_l, lat_r;
    logic       nxt_l, nxt_r;
    tok_state_t state_q, state_d;

    // latch values as they will be after this edge
    assign nxt_l = l_wr ? l_val : lat_l;
    assign nxt_r = r_wr ? r_val : lat_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_l <= 1'b1;
            lat_r <= 1'b1;
        end else begin
            lat_l <= nxt_l;
            lat_r <= nxt_r;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= TOK_FREE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TOK_FREE: begin
                if (!nxt_l)      state_d = TOK_HELD_L;
                else if (!nxt_r) state_d = TOK_HELD_R;
            end
            TOK_HELD_L: begin
                if (nxt_l) state_d = nxt_r ? TOK_FREE : TOK_HELD_R;
            end
            TOK_HELD_R: begin
                if (nxt_r) state_d = nxt_l ? TOK_FREE : TOK_HELD_L;
            end
            default: state_d = TOK_FREE;
        endcase
    end

    always_comb begin
        own_l = (state_q == TOK_HELD_L);
        own_r = (state_q == TOK_HELD_R);
    end
endmodule

// File: rtl/sem_read_port.sv
module sem_read_port #(
    parameter int N_TOK  = 8,
    parameter int AW     = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [N_TOK-1:0]  own_vec,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= DATA_W'(1);
        end else if (rd_en) begin
            rdata <= DATA_W'(!own_vec[addr]);
        end
    end
endmodule

// File: rtl/dual_sem_bank.sv
module dual_sem_bank #(
    parameter int N_TOK  = 8,
    parameter int AW     = $clog2(N_TOK),
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_cs,
    input  logic              l_we,
    input  logic [AW-1:0]     l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_cs,
    input  logic              r_we,
    input  logic [AW-1:0]     r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);
    logic [N_TOK-1:0] own_l_vec;
    logic [N_TOK-1:0] own_r_vec;
    logic             l_wr_any, r_wr_any;

    assign l_wr_any = l_cs && l_we;
    assign r_wr_any = r_cs && r_we;

    for (genvar i = 0; i < N_TOK; i++) begin : g_tok
        sem_token_cell u_cell (
            .clk   (clk),
            .rst   (rst),
            .l_wr  (l_wr_any && (l_addr == AW'(i))),
            .l_val (l_wdata[0]),
            .r_wr  (r_wr_any && (r_addr == AW'(i))),
            .r_val (r_wdata[0]),
            .own_l (own_l_vec[i]),
            .own_r (own_r_vec[i])
        );
    end

    sem_read_port #(.N_TOK(N_TOK), .AW(AW), .DATA_W(DATA_W)) u_rd_l (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (l_cs && !l_we),
        .addr    (l_addr),
        .own_vec (own_l_vec),
        .rdata   (l_rdata)
    );

    sem_read_port #(.N_TOK(N_TOK), .AW(AW), .DATA_W(DATA_W)) u_rd_r (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (r_cs && !r_we),
        .addr    (r_addr),
        .own_vec (own_r_vec),
        .rdata   (r_rdata)
    );
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
    parameter int N_TOK  = 8,
    parameter int AW     = 3,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              l_cs,
    input logic              l_we,
    input logic [AW-1:0]     l_addr,
    input logic [DATA_W-1:0] l_wdata,
    input logic [DATA_W-1:0] l_rdata,
    input logic              r_cs,
    input logic              r_we,
    input logic [AW-1:0]     r_addr,
    input logic [DATA_W-1:0] r_wdata,
    input logic [DATA_W-1:0] r_rdata,
    input logic [N_TOK-1:0]  own_l_vec,
    input logic [N_TOK-1:0]  own_r_vec
);
    // R1: reset leaves both read outputs at 1
    a_r1_reset_rdata: assert property (@(posedge clk)
        rst |=> (l_rdata == DATA_W'(1)) && (r_rdata == DATA_W'(1)));

    // R2: a left request on a token the right does not own is granted next edge
    a_r2_grant_left: assert property (@(posedge clk) disable iff (rst)
        (l_cs && l_we && !l_wdata[0] && !own_r_vec[l_addr])
        |=> own_l_vec[$past(l_addr)]);

    // R5: a right request loses a same-edge tie with the left
    a_r5_tie_left_wins: assert property (@(posedge clk) disable iff (rst)
        (l_cs && l_we && !l_wdata[0] && r_cs && r_we && !r_wdata[0] &&
         (l_addr == r_addr) && !own_r_vec[r_addr])
        |=> !own_r_vec[$past(r_addr)]);

    // R6: an owner that writes 1 no longer owns the token
    a_r6_release_drops: assert property (@(posedge clk) disable iff (rst)
        (l_cs && l_we && l_wdata[0] && own_l_vec[l_addr])
        |=> !own_l_vec[$past(l_addr)]);

    // R9: read data reflects ownership from before the read edge
    a_r9_read_pre_state: assert property (@(posedge clk) disable iff (rst)
        (r_cs && !r_we) |=> (r_rdata == DATA_W'(!$past(own_r_vec[r_addr]))));

    // R10: read data holds without a read
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !(l_cs && !l_we) |=> $stable(l_rdata));

    // R11: both sides never read ownership of the same token together
    a_r11_mutex_read: assert property (@(posedge clk) disable iff (rst)
        (l_cs && !l_we && r_cs && !r_we && (l_addr == r_addr))
        |=> !(!l_rdata[0] && !r_rdata[0]));
endmodule

bind dual_sem_bank sem_bank_chk #(.N_TOK(N_TOK), .AW(AW), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .l_cs      (l_cs),
    .l_we      (l_we),
    .l_addr    (l_addr),
    .l_wdata   (l_wdata),
    .l_rdata   (l_rdata),
    .r_cs      (r_cs),
    .r_we      (r_we),
    .r_addr    (r_addr),
    .r_wdata   (r_wdata),
    .r_rdata   (r_rdata),
    .own_l_vec (own_l_vec),
    .own_r_vec (own_r_vec)
);

// File: tb/dual_sem_bank_tb_top.sv
`timescale 1ns/1ps
module dual_sem_bank_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       l_cs = 0, l_we = 0, r_cs = 0, r_we = 0;
    logic [2:0] l_addr = 0, r_addr = 0;
    logic [7:0] l_wdata = 0, r_wdata = 0;
    logic [7:0] l_rdata, r_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference model: 1 = idle latch, owner 0 free / 1 left / 2 right
    int lat_l [8];
    int lat_r [8];
    int owner [8];
    int exp_l = 1, exp_r = 1;

    always #2.5 clk = ~clk;

    dual_sem_bank dut_i (
        .clk(clk), .rst(rst),
        .l_cs(l_cs), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_cs(r_cs), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) begin
                lat_l[i] = 1; lat_r[i] = 1; owner[i] = 0;
            end
            exp_l = 1; exp_r = 1;
        end else begin
            if (l_cs && !l_we) exp_l = (owner[l_addr] == 1) ? 0 : 1;
            if (r_cs && !r_we) exp_r = (owner[r_addr] == 2) ? 0 : 1;
            if (l_cs && l_we) lat_l[l_addr] = int'(l_wdata[0]);
            if (r_cs && r_we) lat_r[r_addr] = int'(r_wdata[0]);
            for (int i = 0; i < 8; i++) begin
                if (owner[i] == 0) begin
                    if (lat_l[i] == 0) owner[i] = 1;
                    else if (lat_r[i] == 0) owner[i] = 2;
                end else if (owner[i] == 1) begin
                    if (lat_l[i] == 1) owner[i] = (lat_r[i] == 0) ? 2 : 0;
                end else begin
                    if (lat_r[i] == 1) owner[i] = (lat_l[i] == 0) ? 1 : 0;
                end
            end
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock model comparison
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R2 model left", l_rdata, 8'(exp_l));
            check("R11 model right", r_rdata, 8'(exp_r));
        end
    end

    task automatic step(input logic lc, input logic lw, input logic [2:0] la, input logic [7:0] ld,
                        input logic rc, input logic rw, input logic [2:0] ra, input logic [7:0] rd);
        l_cs = lc; l_we = lw; l_addr = la; l_wdata = ld;
        r_cs = rc; r_we = rw; r_addr = ra; r_wdata = rd;
        @(negedge clk);
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 left after reset", l_rdata, 8'h01);
        check("R1 right after reset", r_rdata, 8'h01);
        step(1, 0, 0, 0, 1, 0, 0, 0);
        check("R1 left read free", l_rdata, 8'h01);
        check("R1 right read free", r_rdata, 8'h01);

        // R2: left takes token 0
        step(1, 1, 0, 8'h00, 0, 0, 0, 0);
        step(1, 0, 0, 0, 1, 0, 0, 0);
        check("R2 owner reads 0", l_rdata, 8'h00);
        check("R2 other reads 1", r_rdata, 8'h01);

        // R3: right requests owned token, stays pending
        step(0, 0, 0, 0, 1, 1, 0, 8'h00);
        step(1, 0, 0, 0, 1, 0, 0, 0);
        check("R3 owner keeps", l_rdata, 8'h00);
        check("R3 requester locked out", r_rdata, 8'h01);

        // R8: owner writes 0 again
        step(1, 1, 0, 8'h00, 0, 0, 0, 0);
        step(1, 0, 0, 0, 1, 0, 0, 0);
        check("R8 owner unchanged", l_rdata, 8'h00);
        check("R8 other unchanged", r_rdata, 8'h01);

        // R4 + R9: owner releases while right reads in the same cycle
        step(1, 1, 0, 8'h01, 1, 0, 0, 0);
        check("R9 read sees pre-write state", r_rdata, 8'h01);
        step(1, 0, 0, 0, 1, 0, 0, 0);
        check("R4 handover to right", r_rdata, 8'h00);
        check("R4 left lost", l_rdata, 8'h01);

        // R6: right releases with nothing pending
        step(0, 0, 0, 0, 1, 1, 0, 8'h01);
        step(1, 0, 0, 0, 1, 0, 0, 0);
        check("R6 free left", l_rdata, 8'h01);
        check("R6 free right", r_rdata, 8'h01);

        // R5: tie on token 3
        step(1, 1, 3, 8'h00, 1, 1, 3, 8'h00);
        step(1, 0, 3, 0, 1, 0, 3, 0);
        check("R5 left wins tie", l_rdata, 8'h00);
        check("R5 right loses tie", r_rdata, 8'h01);

        // R6: right withdraws, then left releases
        step(0, 0, 0, 0, 1, 1, 3, 8'h01);
        step(1, 1, 3, 8'h01, 0, 0, 0, 0);
        step(1, 0, 3, 0, 1, 0, 3, 0);
        check("R6 withdrawn no grab", r_rdata, 8'h01);
        check("R6 token free", l_rdata, 8'h01);

        // R7: independent tokens
        step(1, 1, 5, 8'h00, 1, 1, 6, 8'h00);
        step(1, 0, 5, 0, 1, 0, 6, 0);
        check("R7 left owns 5", l_rdata, 8'h00);
        check("R7 right owns 6", r_rdata, 8'h00);
        step(1, 0, 6, 0, 1, 0, 5, 0);
        check("R7 left not 6", l_rdata, 8'h01);
        check("R7 right not 5", r_rdata, 8'h01);
        step(1, 0, 4, 0, 1, 0, 4, 0);
        check("R7 token 4 untouched", l_rdata, 8'h01);
        step(1, 1, 5, 8'h01, 1, 1, 6, 8'h01);

        // R10: upper write bits ignored, read data holds
        step(1, 1, 2, 8'hFE, 0, 0, 0, 0);
        step(1, 0, 2, 0, 0, 0, 0, 0);
        check("R10 bit0 zero requests", l_rdata, 8'h00);
        idle();
        idle();
        check("R10 rdata holds", l_rdata, 8'h00);
        step(1, 1, 2, 8'h01, 0, 0, 0, 0);
        step(1, 0, 2, 0, 0, 0, 0, 0);
        check("R10 bit0 one releases", l_rdata, 8'h01);

        // random phase compared against the model each clock
        for (int n = 0; n < 3000; n++) begin
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 3'($urandom_range(0, 2)),
                 8'($urandom),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 3'($urandom_range(0, 2)),
                 8'($urandom));
        end
        idle();
        done = 1;
        finish_run();
    end
endmodule